// File: doc/BRIEF.md
# Power-Down Configuration Retention Controller

This block decides the fate of a device's configuration register bank when the active-low power-down pin is pulled low. The pin passes through a two-stage synchronizer, and the controller acts on a falling edge of the synchronized level. It then takes one of two paths. On the first path it emulates a cold start: it raises a one-cycle register-reset request, which returns the whole bank to its default contents, and it parks in a latches-open state until the pin is released. On the second path it keeps the bank untouched for the whole power-down and resumes normal running when the pin goes high again.

Two bits of configuration byte 0 choose the path. Bit 0 is the restore-select control and bit 3 is the management-mode control. While management mode is set, the controller ignores the restore-select bit and never issues a reset in response to power-down. A register port writes bytes into the bank and reads them back. Writes take effect only while the controller is running.

Top module: `pd_retention_ctrl`

## Requirements
- R1: While `rstN` is low, every bank byte holds its default (byte 0 = 0x00, byte 1 = 0x1E, byte 2 = 0x3C, byte 3 = 0x5A) and `pdState` reads 2 (latches open). After `rstN` rises with `pdN` high, `pdState` becomes 0 (run) on the third rising clock edge.
- R2: In state 0, a write with `wrEn` high stores `wrData` into byte `wrAddr` on the clock edge. `rdData` then shows that byte for `rdAddr` with no extra delay.
- R3: Writes are ignored in every state other than 0, and the addressed byte keeps its value.
- R4: In state 0, if byte 0 bit 0 and bit 3 are both 0, then `pdN` going low makes `pdState` read 3 and `regResetReq` go high on the third rising edge. `regResetReq` stays high for exactly one cycle. On the next edge all bytes return to their defaults and `pdState` reads 2.
- R5: In state 0, if byte 0 bit 0 is 1 and bit 3 is 0, then `pdN` going low makes `pdState` read 1 (hold) on the third rising edge. No reset request is raised and the bank is kept.
- R6: In state 0, if byte 0 bit 3 is 1, `pdN` going low always leads to state 1, whatever bit 0 holds. `regResetReq` never rises as a result.
- R7: From state 1, `pdN` going high returns `pdState` to 0 on the third rising edge, with every byte as it was before power-down.
- R8: State 2 is held for as long as `pdN` stays low. When `pdN` rises, `pdState` becomes 0 on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low cold reset |
| pdN | input | 1 | Asynchronous active-low power-down pin |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Byte address for writes |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Byte address for reads |
| rdData | output | 8 | Combinational read data |
| regResetReq | output | 1 | One-cycle register-reset request |
| pdState | output | 2 | Controller state: 0 run, 1 hold, 2 latches open, 3 reset pulse |

## Verification
Every change on `pdN` reaches `pdState` on the third rising edge after the pin changes: two edges pass through the synchronizer and one more updates the state register. The bank is cleared one edge after that. A write is visible on `rdData` right after its own edge. The bench drives inputs on falling edges and moves forward one edge at a time. At the falling edge after the second edge it confirms the state has not yet changed, and at the falling edge after the third edge it confirms the new state and the request pulse. The bank contents are checked one edge later. Random write traffic and random power-down lengths are compared against a mirror of the bank kept in the bench.

// File: rtl/pdret_pkg.sv
package pdret_pkg;
  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_HOLD     = 2'd1,
    ST_LATCH    = 2'd2,
    ST_RSTPULSE = 2'd3
  } pdState_e;

  typedef struct packed {
    logic clearBank;
    logic writeOk;
  } ctlStrobe_t;
endpackage

// File: rtl/pdret_ctrl.sv
module pdret_ctrl
  import pdret_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pdN,
  input  logic       restoreSel,
  input  logic       mgmtMode,
  output ctlStrobe_t strobe,
  output pdState_e   state
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic pdSync, pdPrev, pdFall;
  pdState_e stateNext;

  assign pdSync = syncQ[SYNC_STAGES-1];
  assign pdFall = pdPrev & ~pdSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= '0;
      pdPrev <= 1'b0;
      state  <= ST_LATCH;
    end else begin
      syncQ  <= {syncQ[SYNC_STAGES-2:0], pdN};
      pdPrev <= pdSync;
      state  <= stateNext;
    end
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_RUN: begin
        if (pdFall) begin
          if (mgmtMode || restoreSel) stateNext = ST_HOLD;
          else                        stateNext = ST_RSTPULSE;
        end
      end
      ST_HOLD:     if (pdSync) stateNext = ST_RUN;
      ST_RSTPULSE: stateNext = ST_LATCH;
      ST_LATCH:    if (pdSync) stateNext = ST_RUN;
      default:     stateNext = ST_LATCH;
    endcase
  end

  assign strobe.clearBank = (state == ST_RSTPULSE);
  assign strobe.writeOk   = (state == ST_RUN);

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_RSTPULSE |=> state == ST_LATCH);
  assert_mgmt_no_reset_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && mgmtMode) |=> state != ST_RSTPULSE);
  assert_hold_exit_R7: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_HOLD |=> (state == ST_HOLD || state == ST_RUN));
  assert_latch_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LATCH && !pdSync) |=> state == ST_LATCH);
endmodule

// File: rtl/pdret_bank.sv
module pdret_bank
  import pdret_pkg::*;
#(
  parameter int NUM_BYTES   = 4,
  parameter logic [NUM_BYTES*8-1:0] CFG_DEFAULT = 32'h5A3C_1E00,
  parameter int RESTORE_BIT = 0,
  parameter int MGMT_BIT    = 3,
  localparam int ADDR_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              restoreSel,
  output logic              mgmtMode
);
  logic [NUM_BYTES*8-1:0] bankFlat;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : gByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        bankFlat[b*8 +: 8] <= CFG_DEFAULT[b*8 +: 8];
      else if (strobe.clearBank)
        bankFlat[b*8 +: 8] <= CFG_DEFAULT[b*8 +: 8];
      else if (strobe.writeOk && wrEn && wrAddr == ADDR_W'(b))
        bankFlat[b*8 +: 8] <= wrData;
    end
  end

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < NUM_BYTES; i++)
      if (rdAddr == ADDR_W'(i)) rdData = bankFlat[i*8 +: 8];
  end

  assign restoreSel = bankFlat[RESTORE_BIT];
  assign mgmtMode   = bankFlat[MGMT_BIT];

  assert_clear_defaults_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearBank |=> bankFlat == CFG_DEFAULT);
  assert_locked_bank_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.writeOk && !strobe.clearBank) |=> $stable(bankFlat));
endmodule

// File: rtl/pd_retention_ctrl.sv
module pd_retention_ctrl
  import pdret_pkg::*;
#(
  parameter int NUM_BYTES   = 4,
  parameter logic [NUM_BYTES*8-1:0] CFG_DEFAULT = 32'h5A3C_1E00,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pdN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              regResetReq,
  output logic [1:0]        pdState
);
  ctlStrobe_t strobe;
  pdState_e   state;
  logic       restoreSel, mgmtMode;

  pdret_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .pdN(pdN), .restoreSel(restoreSel),
    .mgmtMode(mgmtMode), .strobe(strobe), .state(state)
  );

  pdret_bank #(.NUM_BYTES(NUM_BYTES), .CFG_DEFAULT(CFG_DEFAULT)) uBank (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .restoreSel(restoreSel), .mgmtMode(mgmtMode)
  );

  assign regResetReq = strobe.clearBank;
  assign pdState     = state;
endmodule

// File: tb/pd_retention_ctrl_test.sv
module pd_retention_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pdN = 1'b1;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic regResetReq;
  logic [1:0] pdState;

  int checks = 0;
  int failures = 0;
  int pulseSeen = 0;
  int pulseExp = 0;
  bit done = 1'b0;
  logic [7:0] model [4];

  always #5 clk = ~clk;

  pd_retention_ctrl uut (
    .clk(clk), .rstN(rstN), .pdN(pdN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .regResetReq(regResetReq), .pdState(pdState)
  );

  always @(negedge clk) if (rstN && regResetReq) pulseSeen++;

  function automatic logic [7:0] defByte(int i);
    case (i)
      0: defByte = 8'h00;
      1: defByte = 8'h1E;
      2: defByte = 8'h3C;
      default: defByte = 8'h5A;
    endcase
  endfunction

  function automatic bit expectReset(logic [7:0] b0);
    expectReset = !b0[3] && !b0[0];
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkBank(string req);
    for (int i = 0; i < 4; i++) begin
      rdAddr = 2'(i);
      #1;
      check(req, rdData, model[i]);
    end
  endtask

  task automatic writeByte(int a, logic [7:0] d);
    wrEn = 1'b1; wrAddr = 2'(a); wrData = d;
    step();
    wrEn = 1'b0;
    model[a] = d;
    rdAddr = 2'(a);
    #1;
    check("R2 write readback", rdData, d);
  endtask

  task automatic pdCycle(int lowCyc);
    bit rstExp = expectReset(model[0]);
    string tag = rstExp ? "R4" : (model[0][3] ? "R6" : "R5");
    int parked = rstExp ? 2 : 1;
    int a;
    logic [7:0] keep;
    pdN = 1'b0;
    step(); step();
    check({tag, " still run after two edges"}, pdState, 0);
    step();
    check({tag, " state on third edge"}, pdState, rstExp ? 3 : 1);
    check({tag, " request on third edge"}, regResetReq, rstExp);
    step();
    check({tag, " request is one cycle"}, regResetReq, 0);
    check({tag, " parked state"}, pdState, parked);
    if (rstExp) begin
      for (int i = 0; i < 4; i++) model[i] = defByte(i);
      pulseExp++;
    end
    checkBank(rstExp ? "R4 defaults" : "R5 kept");
    a = $urandom_range(0, 3);
    keep = model[a];
    wrEn = 1'b1; wrAddr = 2'(a); wrData = ~keep;
    step();
    wrEn = 1'b0; rdAddr = 2'(a);
    #1;
    check("R3 write ignored", rdData, keep);
    repeat (lowCyc) step();
    check(rstExp ? "R8 held while low" : "R7 held while low", pdState, parked);
    pdN = 1'b1;
    step(); step();
    check(rstExp ? "R8 not yet run" : "R7 not yet run", pdState, parked);
    step();
    check(rstExp ? "R8 back to run" : "R7 back to run", pdState, 0);
    checkBank("R7 bank after exit");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) model[i] = defByte(i);
    @(negedge clk); @(negedge clk);
    check("R1 reset state", pdState, 2);
    checkBank("R1 reset defaults");
    rstN = 1'b1;
    step(); step();
    check("R1 not yet run", pdState, 2);
    step();
    check("R1 run after reset", pdState, 0);

    // directed corner cases
    writeByte(1, 8'hA7);
    writeByte(0, 8'h00);
    pdCycle(3);
    writeByte(0, 8'h01);
    writeByte(2, 8'h99);
    pdCycle(5);
    writeByte(0, 8'h09);
    pdCycle(2);
    writeByte(0, 8'h08);
    writeByte(3, 8'h44);
    pdCycle(4);

    // random traffic
    for (int it = 0; it < 40; it++) begin
      int n = $urandom_range(1, 4);
      for (int k = 0; k < n; k++)
        writeByte($urandom_range(0, 3), 8'($urandom));
      if ($urandom_range(0, 2) == 0) writeByte(0, 8'($urandom) & 8'h09);
      pdCycle($urandom_range(0, 20));
    end

    check("R4 R6 total reset pulses", pulseSeen, pulseExp);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule